// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

A single DMA channel that moves 32-bit words from a source address to a destination address, driven entirely by descriptors held in memory. Software places a pointer in the next-descriptor register, then writes the control register with the enable and fetch bits set. The channel reads a four-word descriptor from that pointer: byte count at +0, source at +4, destination at +8 and next pointer at +12. It then copies the data one word at a time through a word-wide memory port. Each address either steps by four bytes per word or stays fixed, so the same engine serves memory-to-peripheral, peripheral-to-memory and memory-to-memory copies.

When a descriptor finishes, the channel raises a completion status bit, which reaches the interrupt pin through a mask. If chaining is enabled and the next pointer is nonzero, the channel goes on to fetch the next descriptor, so a circular list runs with no further help from software. Clearing the enable bit pauses the channel at the next word boundary and setting it again resumes. A separate abort bit terminates the channel. One descriptor moves at most `MAX_BYTES` bytes (64 KiB by default). A larger count is clipped when it is loaded. The burst-size field (control bits 8:6) is stored and reads back, but it does not change how words move on the single-word port.

The memory port is a request channel and a read-response channel, each with valid/ready. The engine holds a request stable for as long as `mem_req_valid` is high and `mem_req_ready` is low. It keeps at most one read outstanding and raises `mem_rsp_ready` only while it waits for that read. A write counts as complete once its request is accepted.

Top module: `dmach_engine`

Register map (byte offsets on `reg_addr`; reads are combinational, writes take effect on `reg_we`):

| Offset | Contents |
|---|---|
| 0x00 | remaining byte count |
| 0x10 | current source address |
| 0x20 | current destination address |
| 0x30 | next-descriptor pointer |
| 0x40 | control |
| 0x70 | address of the descriptor being executed |
| 0x80 | interrupt mask, bit 0 |
| 0xA0 | completion status, bit 0 |

Control register bits:

| Bit(s) | Meaning |
|---|---|
| 3:2 | source direction |
| 5:4 | destination direction |
| 8:6 | burst size (stored only) |
| 9 | chain |
| 12 | enable |
| 13 | fetch request |
| 14 | active (read-only) |
| 20 | abort |

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `mem_req_valid` is 0.
- R2: Once enable (bit 12) and the fetch bit (bit 13) are both set and the channel is idle, it reads the descriptor words at pointer+0, +4, +8 and +12 (count, source, destination, next). Register 0x70 then shows the pointer that was fetched. Bit 13 reads 1 until the fetch starts and reads 0 after that.
- R3: Each word is read from the current source address and written to the current destination address. The byte count drops by 4 per word and never goes below 0, so a count that is not a multiple of 4 moves ceil(count/4) words. A count of 0 completes at once with no data moved.
- R4: In each direction field, bit 1 = 0 steps that address by +4 after each word, and bit 1 = 1 holds it fixed (code 00 increments, code 10 holds). The source field is control bits 3:2 and the destination field is bits 5:4.
- R5: With chain (bit 9) set and a nonzero next pointer, a finished descriptor is followed by a fetch from that pointer, so a circular list runs without end.
- R6: With chain clear, or a next pointer of 0, the channel goes idle after the descriptor and active (bit 14) reads 0. Register 0x30 holds the fetched next pointer.
- R7: Status bit 0 sets when a descriptor completes. `irq` = status AND mask bit 0. Writing 0 to status bit 0 clears it, and writing 1 has no effect. A completion in the same cycle as a clear leaves the bit set.
- R8: Clearing enable pauses the channel at the next word boundary. Count and addresses then stay frozen and active stays 1. Setting enable again finishes the transfer with the correct data.
- R9: Writing 1 to bit 20 stops the channel at the next word boundary, outside any descriptor fetch. Enable and active clear, the next pointer is unchanged, the aborted descriptor sets no status, and the count left is a multiple of 4.
- R10: While running, registers 0x10 and 0x20 show the live addresses, so that source minus start equals the bytes already moved when the source increments.
- R11: While active is 1, software writes to 0x00, 0x10 and 0x20 are ignored.
- R12: A pending request keeps its address, direction and data until accepted. After a read is accepted, no new request is made until its response arrives.
- R13: A descriptor byte count above 65536 is loaded as 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 8 | register byte offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for reg_addr |
| mem_req_valid | output | 1 | memory request valid |
| mem_req_ready | input | 1 | memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | word byte address |
| mem_req_wdata | output | 32 | write data |
| mem_rsp_valid | input | 1 | read data valid |
| mem_rsp_ready | output | 1 | engine waiting for read data |
| mem_rsp_rdata | input | 32 | read data |
| irq | output | 1 | masked completion interrupt |

## Verification
Two events can land on the same clock edge: a descriptor completion setting status bit 0, and a software write clearing that bit. The bench provokes this by writing 0 to the status register on every single cycle while a one-word descriptor runs with the mask enabled. The bit survives only if set wins the tie, in which case `irq` is seen high for a cycle. If clear won, `irq` would never rise. The memory model adds random request stalls and random response delays, so pause, abort and completion all fall on varied cycles relative to the memory handshake.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DREQ,
    S_DRSP,
    S_BOUND,
    S_RREQ,
    S_RRSP,
    S_WREQ
  } xfer_state_e;

  localparam logic [7:0] OFS_CNT  = 8'h00;
  localparam logic [7:0] OFS_SRC  = 8'h10;
  localparam logic [7:0] OFS_DST  = 8'h20;
  localparam logic [7:0] OFS_NDP  = 8'h30;
  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_CUR  = 8'h70;
  localparam logic [7:0] OFS_MASK = 8'h80;
  localparam logic [7:0] OFS_STAT = 8'hA0;

  localparam int CB_SRC_LO = 2;
  localparam int CB_DST_LO = 4;
  localparam int CB_BST_LO = 6;
  localparam int CB_CHAIN  = 9;
  localparam int CB_EN     = 12;
  localparam int CB_FETCH  = 13;
  localparam int CB_ACT    = 14;
  localparam int CB_ABORT  = 20;

  typedef struct packed {
    logic       enable;
    logic       chain;
    logic [2:0] burst;
    logic [1:0] dst_dir;
    logic [1:0] src_dir;
  } chan_cfg_t;

endpackage

// File: rtl/dmach_addr_unit.sv
module dmach_addr_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_val,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          hold,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP_BYTES = AW'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (ld) begin
      addr <= ld_val;
    end else if (step) begin
      if (!hold) addr <= addr + STEP_BYTES;
    end else if (sw_we) begin
      addr <= sw_val;
    end
  end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  input  logic          done_evt,
  input  logic          abort_take,
  input  logic          fetch_take,
  input  logic          ndp_ld,
  input  logic [AW-1:0] ndp_val,
  output chan_cfg_t     cfg,
  output logic          fetch_req,
  output logic          abort_pend,
  output logic [AW-1:0] ndp,
  output logic          mask_q,
  output logic          stat_q,
  output logic          irq
);
  logic wr_ctrl, wr_ndp, wr_mask, wr_stat;

  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  assign wr_ndp  = reg_we && (reg_addr == OFS_NDP);
  assign wr_mask = reg_we && (reg_addr == OFS_MASK);
  assign wr_stat = reg_we && (reg_addr == OFS_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg        <= '0;
      fetch_req  <= 1'b0;
      abort_pend <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg.enable  <= reg_wdata[CB_EN];
        cfg.chain   <= reg_wdata[CB_CHAIN];
        cfg.burst   <= reg_wdata[CB_BST_LO +: 3];
        cfg.dst_dir <= reg_wdata[CB_DST_LO +: 2];
        cfg.src_dir <= reg_wdata[CB_SRC_LO +: 2];
        if (reg_wdata[CB_FETCH]) fetch_req  <= 1'b1;
        if (reg_wdata[CB_ABORT]) abort_pend <= 1'b1;
      end
      if (fetch_take) fetch_req <= 1'b0;
      if (abort_take) begin
        cfg.enable <= 1'b0;
        abort_pend <= 1'b0;
        fetch_req  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ndp <= '0;
    end else if (ndp_ld) begin
      ndp <= ndp_val;
    end else if (wr_ndp) begin
      ndp <= reg_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[0];
      if (wr_stat && !reg_wdata[0]) stat_q <= 1'b0;
      if (done_evt) stat_q <= 1'b1;
    end
  end

  assign irq = stat_q & mask_q;
endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer
  import dmach_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_BYTES = 65536
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  input  chan_cfg_t       cfg,
  input  logic            fetch_req,
  input  logic            abort_pend,
  input  logic [AW-1:0]   ndp,
  output logic            done_evt,
  output logic            abort_take,
  output logic            fetch_take,
  output logic            ndp_ld,
  output logic [AW-1:0]   ndp_val,
  output logic            active,
  output logic [$clog2(MAX_BYTES+1)-1:0] cnt,
  output logic [AW-1:0]   src,
  output logic [AW-1:0]   dst,
  output logic [AW-1:0]   cur,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [AW-1:0]   mem_req_addr,
  output logic [31:0]     mem_req_wdata,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [31:0]     mem_rsp_rdata
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int NPTR  = 2;

  xfer_state_e st;
  logic [1:0]  widx;
  logic [31:0] data_q;
  logic        rsp_hit, wr_done, chain_go;

  logic [NPTR-1:0] p_swe, p_ld, p_hold;
  logic [AW-1:0]   p_addr [NPTR];

  function automatic logic [CNT_W-1:0] clip(input logic [31:0] v);
    if (v > 32'(MAX_BYTES)) return CNT_W'(MAX_BYTES);
    else return v[CNT_W-1:0];
  endfunction

  assign active     = (st != S_IDLE);
  assign rsp_hit    = mem_rsp_valid && mem_rsp_ready;
  assign wr_done    = (st == S_WREQ) && mem_req_ready;
  assign abort_take = abort_pend && ((st == S_IDLE) || (st == S_BOUND));
  assign fetch_take = (st == S_IDLE) && !abort_pend && cfg.enable && fetch_req;
  assign done_evt   = (st == S_BOUND) && !abort_pend && (cnt == '0);
  assign chain_go   = cfg.chain && (ndp != '0);
  assign ndp_ld     = (st == S_DRSP) && rsp_hit && (widx == 2'd3);
  assign ndp_val    = mem_rsp_rdata[AW-1:0];

  assign p_swe[0]  = reg_we && (reg_addr == OFS_SRC) && !active;
  assign p_swe[1]  = reg_we && (reg_addr == OFS_DST) && !active;
  assign p_ld[0]   = (st == S_DRSP) && rsp_hit && (widx == 2'd1);
  assign p_ld[1]   = (st == S_DRSP) && rsp_hit && (widx == 2'd2);
  assign p_hold[0] = cfg.src_dir[1];
  assign p_hold[1] = cfg.dst_dir[1];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dmach_addr_unit #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .sw_we  (p_swe[g]),
      .sw_val (reg_wdata[AW-1:0]),
      .ld     (p_ld[g]),
      .ld_val (mem_rsp_rdata[AW-1:0]),
      .step   (wr_done),
      .hold   (p_hold[g]),
      .addr   (p_addr[g])
    );
  end

  assign src = p_addr[0];
  assign dst = p_addr[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      widx   <= '0;
      cnt    <= '0;
      cur    <= '0;
      data_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (reg_we && (reg_addr == OFS_CNT)) cnt <= clip(reg_wdata);
          if (fetch_take) begin
            st   <= S_DREQ;
            cur  <= ndp;
            widx <= '0;
          end
        end
        S_DREQ: if (mem_req_ready) st <= S_DRSP;
        S_DRSP: begin
          if (rsp_hit) begin
            if (widx == 2'd0) cnt <= clip(mem_rsp_rdata);
            if (widx == 2'd3) begin
              st <= S_BOUND;
            end else begin
              widx <= widx + 2'd1;
              st   <= S_DREQ;
            end
          end
        end
        S_BOUND: begin
          if (abort_pend) begin
            st <= S_IDLE;
          end else if (cnt == '0) begin
            if (chain_go) begin
              st   <= S_DREQ;
              cur  <= ndp;
              widx <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else if (cfg.enable) begin
            st <= S_RREQ;
          end
        end
        S_RREQ: if (mem_req_ready) st <= S_RRSP;
        S_RRSP: begin
          if (rsp_hit) begin
            data_q <= mem_rsp_rdata;
            st     <= S_WREQ;
          end
        end
        S_WREQ: begin
          if (mem_req_ready) begin
            cnt <= (cnt > CNT_W'(4)) ? cnt - CNT_W'(4) : '0;
            st  <= S_BOUND;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = dst;
    mem_rsp_ready = 1'b0;
    unique case (st)
      S_DREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = cur + AW'({widx, 2'b00});
      end
      S_RREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src;
      end
      S_WREQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
      end
      S_DRSP, S_RRSP: mem_rsp_ready = 1'b1;
      default: ;
    endcase
  end

  assign mem_req_wdata = data_q;
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
  import dmach_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_BYTES = 65536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [31:0]   mem_rsp_rdata,
  output logic          irq
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  chan_cfg_t        cfg;
  logic             fetch_req, abort_pend, mask_q, stat_q;
  logic             done_evt, abort_take, fetch_take, ndp_ld, active;
  logic [AW-1:0]    ndp, ndp_val, src, dst, cur;
  logic [CNT_W-1:0] cnt;
  logic             cfg_enable, cfg_chain;

  assign cfg_enable = cfg.enable;
  assign cfg_chain  = cfg.chain;

  dmach_regs #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .done_evt   (done_evt),
    .abort_take (abort_take),
    .fetch_take (fetch_take),
    .ndp_ld     (ndp_ld),
    .ndp_val    (ndp_val),
    .cfg        (cfg),
    .fetch_req  (fetch_req),
    .abort_pend (abort_pend),
    .ndp        (ndp),
    .mask_q     (mask_q),
    .stat_q     (stat_q),
    .irq        (irq)
  );

  dmach_xfer #(.AW(AW), .MAX_BYTES(MAX_BYTES)) u_xfer (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .cfg           (cfg),
    .fetch_req     (fetch_req),
    .abort_pend    (abort_pend),
    .ndp           (ndp),
    .done_evt      (done_evt),
    .abort_take    (abort_take),
    .fetch_take    (fetch_take),
    .ndp_ld        (ndp_ld),
    .ndp_val       (ndp_val),
    .active        (active),
    .cnt           (cnt),
    .src           (src),
    .dst           (dst),
    .cur           (cur),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_rdata (mem_rsp_rdata)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CNT:  reg_rdata = 32'(cnt);
      OFS_SRC:  reg_rdata = 32'(src);
      OFS_DST:  reg_rdata = 32'(dst);
      OFS_NDP:  reg_rdata = 32'(ndp);
      OFS_CUR:  reg_rdata = 32'(cur);
      OFS_MASK: reg_rdata = {31'b0, mask_q};
      OFS_STAT: reg_rdata = {31'b0, stat_q};
      OFS_CTRL: begin
        reg_rdata[CB_SRC_LO +: 2] = cfg.src_dir;
        reg_rdata[CB_DST_LO +: 2] = cfg.dst_dir;
        reg_rdata[CB_BST_LO +: 3] = cfg.burst;
        reg_rdata[CB_CHAIN]       = cfg.chain;
        reg_rdata[CB_EN]          = cfg.enable;
        reg_rdata[CB_FETCH]       = fetch_req;
        reg_rdata[CB_ACT]         = active;
        reg_rdata[CB_ABORT]       = abort_pend;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmach_checker.sv
module dmach_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [31:0]   mem_req_wdata,
  input logic          active,
  input logic          enable,
  input logic          chain,
  input logic          status,
  input logic          abort_take,
  input logic          done_evt
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  p_one_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_we) |=> !mem_req_valid);

  p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> (!active && !enable));

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_take && !status) |=> !status);

  p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> status);

  p_chain_off_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !chain) |=> !active);
endmodule

bind dmach_engine dmach_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .active        (active),
  .enable        (cfg_enable),
  .chain         (cfg_chain),
  .status        (stat_q),
  .abort_take    (abort_take),
  .done_evt      (done_evt)
);

// File: tb/dmach_engine_test.sv
module dmach_engine_test;
  localparam int CYC = 4;
  localparam logic [31:0] EN = 32'h1 << 12, FE = 32'h1 << 13, CH = 32'h1 << 9;
  localparam logic [31:0] AB = 32'h1 << 20, SH = 32'h2 << 2, DH = 32'h2 << 4;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid, mem_rsp_ready, irq;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;

  int total = 0, bad = 0, viol = 0;
  logic [31:0] mem [0:1023];
  logic bw_en = 0;
  logic [31:0] bw_addr = 0, bw_data = 0;

  always #(CYC/2) clk = ~clk;

  dmach_engine uut (.*);

  // memory model: random stalls and response delays
  logic pend = 0, last_stall = 0;
  logic [1:0] dly = 0;
  logic [31:0] pdata = 0, last_addr = 0;
  initial begin mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_rdata = 0; end
  always @(posedge clk) begin
    if (bw_en) mem[bw_addr[11:2]] <= bw_data;
    mem_req_ready <= ($urandom % 4) != 0;
    if (last_stall && (!mem_req_valid || mem_req_addr != last_addr)) viol <= viol + 1;
    last_stall <= mem_req_valid && !mem_req_ready;
    last_addr  <= mem_req_addr;
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[11:2]] <= mem_req_wdata;
      else begin pend <= 1; pdata <= mem[mem_req_addr[11:2]]; dly <= 2'($urandom % 3); end
    end
    if (pend) begin
      if (dly == 0) begin mem_rsp_valid <= 1; mem_rsp_rdata <= pdata; pend <= 0; end
      else dly <= dly - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bw_en = 1; bw_addr = a; bw_data = d;
    @(negedge clk); bw_en = 0;
  endtask

  task automatic desc(input logic [31:0] at, input logic [31:0] c, input logic [31:0] s,
                      input logic [31:0] d, input logic [31:0] n);
    poke(at, c); poke(at + 4, s); poke(at + 8, d); poke(at + 12, n);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h40, v);
      if (v[13] == 0 && v[14] == 0) return;
    end
    chk(req, 32'hFFFF_FFFF, 32'h0);
  endtask

  function automatic logic [31:0] fin_addr(input logic [31:0] base, input logic hold, input int n);
    return hold ? base : base + 32'(4 * n);
  endfunction

  initial begin : watchdog
    #(CYC * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, c1, s1, c2, s2, cnt, ctrl;
    logic [31:0] sv [64];
    logic [31:0] ev [64];
    logic sh, dh, seen;
    int n, done_cnt;
    v = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h40, v); chk("R1 ctrl", v, 0);
    rd(8'h00, v); chk("R1 count", v, 0);
    rd(8'hA0, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 req_valid", {31'b0, mem_req_valid}, 0);

    // R2 R3 R4 R10: random single descriptors
    for (int it = 0; it < 8; it++) begin
      cnt = (it == 0) ? 0 : ($urandom % 48) + 1;
      sh = $urandom % 2; dh = $urandom % 2;
      for (int i = 0; i < 16; i++) begin
        sv[i] = $urandom; poke(32'h400 + 4 * i, sv[i]);
        ev[i] = 32'hDEAD_0000 | i; poke(32'h800 + 4 * i, ev[i]);
      end
      n = (cnt + 3) / 4;
      for (int i = 0; i < n; i++) ev[dh ? 0 : i] = sv[sh ? 0 : i];
      desc(32'h100, cnt, 32'h400, 32'h800, 32'h0);
      wr(8'hA0, 0);
      wr(8'h30, 32'h100);
      ctrl = EN | FE | (sh ? SH : 0) | (dh ? DH : 0) | (($urandom % 2) ? CH : 0);
      wr(8'h40, ctrl);
      wait_idle("R2 run");
      c1 = 0;
      for (int i = 0; i < 16; i++) if (mem[(32'h800 >> 2) + i] !== ev[i]) c1++;
      chk("R3 R4 dst data mismatches", c1, 0);
      rd(8'h10, v); chk("R4 R10 final src", v, fin_addr(32'h400, sh, n));
      rd(8'h20, v); chk("R4 R10 final dst", v, fin_addr(32'h800, dh, n));
      rd(8'h00, v); chk("R3 count zero", v, 0);
      rd(8'h70, v); chk("R2 current desc", v, 32'h100);
      rd(8'hA0, v); chk("R7 status set", v, 1);
      chk("R7 irq masked", {31'b0, irq}, 0);
      rd(8'h40, v); chk("R2 R6 fetch and active clear", {30'b0, v[14], v[13]}, 0);
    end

    // R7 status write semantics and mask
    wr(8'hA0, 1); rd(8'hA0, v); chk("R7 write 1 no effect", v, 1);
    wr(8'h80, 1); #1 chk("R7 irq unmasked", {31'b0, irq}, 1);
    wr(8'hA0, 0); #1 chk("R7 irq cleared", {31'b0, irq}, 0);

    // R6 chain off with nonzero next pointer
    poke(32'h900, 32'h5555_AAAA);
    desc(32'h100, 8, 32'h400, 32'h800, 32'h110);
    desc(32'h110, 8, 32'h400, 32'h900, 32'h0);
    wr(8'h30, 32'h100); wr(8'h40, EN | FE);
    wait_idle("R6 run");
    rd(8'h70, v); chk("R6 stayed on first desc", v, 32'h100);
    rd(8'h30, v); chk("R6 next pointer loaded", v, 32'h110);
    chk("R6 second desc not run", mem[32'h900 >> 2], 32'h5555_AAAA);

    // R7 same-cycle set and clear: set must win
    wr(8'hA0, 0);
    desc(32'h100, 4, 32'h400, 32'h800, 32'h0);
    wr(8'h30, 32'h100); wr(8'h40, EN | FE);
    seen = 0;
    for (int i = 0; i < 600 && !seen; i++) begin
      @(negedge clk); reg_we = 1; reg_addr = 8'hA0; reg_wdata = 0;
      @(posedge clk); #1 if (irq) seen = 1;
    end
    @(negedge clk); reg_we = 0;
    chk("R7 set wins over clear", {31'b0, seen}, 1);
    wait_idle("R7 run");

    // R8 R10 R11 pause and resume
    for (int i = 0; i < 16; i++) begin
      sv[i] = $urandom; poke(32'h400 + 4 * i, sv[i]); poke(32'h800 + 4 * i, 0);
    end
    desc(32'h100, 64, 32'h400, 32'h800, 32'h0);
    wr(8'h30, 32'h100); wr(8'h40, EN | FE);
    repeat (40) @(posedge clk);
    wr(8'h40, 0);
    repeat (20) @(posedge clk);
    rd(8'h00, c1); rd(8'h10, s1);
    repeat (20) @(posedge clk);
    rd(8'h00, c2); rd(8'h10, s2);
    chk("R8 count frozen", c2, c1);
    chk("R8 src frozen", s2, s1);
    chk("R10 live src tracks progress", s1 - 32'h400, 64 - c1);
    rd(8'h40, v); chk("R8 active while paused", {31'b0, v[14]}, 1);
    wr(8'h00, 32'h1234); rd(8'h00, v); chk("R11 count write ignored", v, c1);
    wr(8'h10, 32'h0);    rd(8'h10, v); chk("R11 src write ignored", v, s1);
    wr(8'h40, EN);
    wait_idle("R8 resume");
    c1 = 0;
    for (int i = 0; i < 16; i++) if (mem[(32'h800 >> 2) + i] !== sv[i]) c1++;
    chk("R8 data after resume", c1, 0);

    // R5 ring of three descriptors
    desc(32'h100, 8, 32'h400, 32'h800, 32'h110);
    desc(32'h110, 8, 32'h400, 32'h800, 32'h120);
    desc(32'h120, 8, 32'h400, 32'h800, 32'h100);
    wr(8'hA0, 0); wr(8'h80, 1);
    wr(8'h30, 32'h100); wr(8'h40, EN | FE | CH);
    done_cnt = 0;
    for (int i = 0; i < 5000 && done_cnt < 7; i++) begin
      @(posedge clk); #1
      if (irq) begin done_cnt++; wr(8'hA0, 0); end
    end
    chk("R5 ring completions", done_cnt, 7);
    rd(8'h40, v); chk("R5 still active", {31'b0, v[14]}, 1);
    wr(8'h40, CH | AB);
    wait_idle("R9 ring abort");
    wr(8'h80, 0);

    // R9 abort mid-descriptor
    desc(32'h100, 256, 32'h400, 32'h800, 32'h1F0);
    wr(8'hA0, 0);
    wr(8'h30, 32'h100); wr(8'h40, EN | FE | CH | SH | DH);
    repeat (60) @(posedge clk);
    wr(8'h40, CH | SH | DH | AB);
    repeat (30) @(posedge clk);
    rd(8'h40, v); chk("R9 enable and active cleared", {30'b0, v[14], v[12]}, 0);
    rd(8'h30, v); chk("R9 next pointer kept", v, 32'h1F0);
    rd(8'hA0, v); chk("R9 no completion", v, 0);
    rd(8'h00, v);
    chk("R9 stop on word boundary", {31'b0, (v[1:0] == 0) && v > 0 && v < 256}, 1);

    // R13 count clipping
    desc(32'h100, 32'h0010_0000, 32'h400, 32'h800, 32'h0);
    wr(8'h30, 32'h100); wr(8'h40, EN | FE | SH | DH);
    repeat (80) @(posedge clk);
    wr(8'h40, SH | DH);
    repeat (20) @(posedge clk);
    rd(8'h00, v);
    chk("R13 count clipped", {31'b0, v <= 65536 && v > 65000 && v[1:0] == 0}, 1);
    wr(8'h40, AB);
    wait_idle("R13 abort");

    chk("R12 request held while stalled", viol, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule